// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Port-Level Break Control

This block turns bytes into asynchronous serial frames on a single transmit line. Software writes bytes into a small first-in first-out buffer. A shift engine then sends each byte as a start bit, eight data bits, an optional parity bit and one or two stop bits. Every bit lasts a fixed number of pulses of an oversampling enable, which an external rate generator supplies.

Two port-control inputs decide the state of the line whenever the transmitter is disabled: a direction bit and a data bit. While transmit-enable is low, the line shows the port data bit, and the pin driver is on only when the direction bit selects output. Setting port data high before enabling gives a clean idle mark level.

Clearing transmit-enable abandons any frame in progress, empties the buffer and puts the shift engine back to idle in the next clock. Line control passes to the port bits at once. To hold a break, software clears the port data bit and then clears transmit-enable, so the line stays low for as long as software wants.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `tx_end` is 1, `fifo_count` is 0, and `tx_pin_oe` follows `pin_dir`, which reads as input (0) when it is held low.
- R2: While `tx_en` is 0, `tx_pin_o` equals `pin_dat` and `tx_pin_oe` equals `pin_dir` (1 = drive the pin, 0 = release it) in the same cycle, with no clock edge needed.
- R3: While `tx_en` is 1, `tx_pin_oe` is 1. When no frame is in progress the line idles at 1. A frame is one start bit of 0, then the eight data bits least significant first, then the stop bit(s) at 1.
- R4: With `par_en` = 1, a parity bit follows data bit 7. With `par_odd` = 0 the parity bit is the XOR of the data bits (even parity). With `par_odd` = 1 it is the inverse of that XOR (odd parity).
- R5: With `two_stop` = 1 a frame ends with two stop bits; with `two_stop` = 0 it ends with one.
- R6: Each bit of a frame lasts exactly OS_RATE (16) `baud_tick` pulses. A frame begins only on a cycle in which `baud_tick` is 1.
- R7: The buffer holds up to FIFO_DEPTH (4) bytes and sends them in write order. `fifo_full` is 1 when it holds FIFO_DEPTH bytes, and a write made while it is full is dropped.
- R8: `tx_end` is 0 from the start of a frame through the middle of its last stop bit. It is 1 when the buffer is empty and no frame is in progress.
- R9: Clearing `tx_en` abandons the current frame. In the next cycle `tx_end` is 1 and `fifo_count` is 0. Writes made while `tx_en` is 0 are dropped.
- R10: Clearing `pin_dat` and then clearing `tx_en` holds the line at 0 with the driver on, for as long as that state is kept. Setting `tx_en` again gives an idle high line and does not resume the abandoned bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling enable, OS_RATE pulses per bit |
| tx_en | input | 1 | Transmit enable; 0 reinitialises the transmitter |
| pin_dir | input | 1 | Port direction when disabled (1 = output) |
| pin_dat | input | 1 | Port level when disabled |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| wr_valid | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte to write |
| fifo_full | output | 1 | Buffer holds FIFO_DEPTH bytes |
| fifo_count | output | $clog2(FIFO_DEPTH+1) | Bytes waiting in the buffer |
| tx_pin_o | output | 1 | Line level |
| tx_pin_oe | output | 1 | Line driver enable |
| tx_end | output | 1 | Buffer empty and no frame in progress |

## Verification
The pin outputs respond to the enable and port bits in the same cycle, so the bench checks them one time unit after it drives a change. Buffer occupancy and the effect of reinitialisation show up one clock edge later, at the next falling edge. A frame's start bit begins on the first tick edge after the byte reaches the buffer. The scoreboard monitor therefore waits for the line to fall, moves to the middle of the start bit, and then samples every 16 ticks. At each sample it also checks that `tx_end` is low. A separate run with one tick every three cycles counts the length of a start bit, which must be exactly 48 cycles.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_PAR,
        SER_STOP
    } ser_state_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push, pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign count   = st_q.cnt;
    assign rd_data = st_q.mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        push = wr_en && !full;
        pop  = rd_en && !empty;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wp] = wr_data;
                st_d.wp           = ptr_inc(st_q.wp);
            end
            if (pop) begin
                st_d.rp = ptr_inc(st_q.rp);
            end
            if (push && !pop) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (pop && !push) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a flush leaves the buffer empty on the following cycle
    a_r9_flush_empties : assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    // R7: a write into a full buffer with no read leaves it unchanged
    a_r7_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> ($stable(count) && $stable(st_q.wp)));

endmodule

// File: rtl/txb_shift.sv
module txb_shift
    import uart_txb_pkg::*;
#(
    parameter int W  = 8,
    parameter int OS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  frame_cfg_t   cfg,
    input  logic         have_data,
    input  logic [W-1:0] din,
    output logic         pop,
    output logic         line,
    output logic         idle
);
    localparam int OS_W  = (OS > 1) ? $clog2(OS) : 1;
    localparam int BIT_W = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        ser_state_e       st;
        logic [W-1:0]     sh;
        logic [OS_W-1:0]  os_cnt;
        logic [BIT_W-1:0] bit_cnt;
        logic             par;
        logic             stop2;
        frame_cfg_t       cfg;
        logic             line;
    } shift_st_t;

    localparam shift_st_t SHIFT_RST = '{
        st: SER_IDLE, sh: '0, os_cnt: '0, bit_cnt: '0,
        par: 1'b0, stop2: 1'b0, cfg: '0, line: 1'b1
    };

    shift_st_t    st_d, st_q;
    logic         last_tick;
    logic [W-1:0] nsh;
    logic         npar;

    assign line = st_q.line;
    assign idle = (st_q.st == SER_IDLE);

    always_comb begin
        st_d      = st_q;
        pop       = 1'b0;
        last_tick = tick && (st_q.os_cnt == OS_W'(OS - 1));
        nsh       = st_q.sh >> 1;
        npar      = st_q.par ^ st_q.sh[0];
        if (!enable) begin
            st_d = SHIFT_RST;
        end else if (st_q.st == SER_IDLE) begin
            st_d.line = 1'b1;
            if (tick && have_data) begin
                pop          = 1'b1;
                st_d.st      = SER_START;
                st_d.sh      = din;
                st_d.cfg     = cfg;
                st_d.par     = cfg.par_odd;
                st_d.os_cnt  = '0;
                st_d.bit_cnt = '0;
                st_d.line    = 1'b0;
            end
        end else begin
            if (tick) begin
                st_d.os_cnt = last_tick ? '0 : st_q.os_cnt + 1'b1;
            end
            if (last_tick) begin
                unique case (st_q.st)
                    SER_START: begin
                        st_d.st      = SER_DATA;
                        st_d.line    = st_q.sh[0];
                        st_d.bit_cnt = '0;
                    end
                    SER_DATA: begin
                        st_d.sh  = nsh;
                        st_d.par = npar;
                        if (st_q.bit_cnt == BIT_W'(W - 1)) begin
                            if (st_q.cfg.par_en) begin
                                st_d.st   = SER_PAR;
                                st_d.line = npar;
                            end else begin
                                st_d.st    = SER_STOP;
                                st_d.line  = 1'b1;
                                st_d.stop2 = st_q.cfg.two_stop;
                            end
                        end else begin
                            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                            st_d.line    = nsh[0];
                        end
                    end
                    SER_PAR: begin
                        st_d.st    = SER_STOP;
                        st_d.line  = 1'b1;
                        st_d.stop2 = st_q.cfg.two_stop;
                    end
                    SER_STOP: begin
                        st_d.line = 1'b1;
                        if (st_q.stop2) begin
                            st_d.stop2 = 1'b0;
                        end else begin
                            st_d.st = SER_IDLE;
                        end
                    end
                    default: st_d = SHIFT_RST;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SHIFT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: dropping the enable returns the engine to idle on the next cycle
    a_r9_reinit_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> idle);

    // R6: a frame starts only after a tick edge
    a_r6_start_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(tick));

    // R3: the first bit of every frame is a low start bit
    a_r3_start_low : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> !line);

endmodule

// File: rtl/txb_pin.sv
module txb_pin (
    input  logic tx_en,
    input  logic pin_dir,
    input  logic pin_dat,
    input  logic ser_line,
    output logic pin_o,
    output logic pin_oe
);
    always_comb begin
        if (tx_en) begin
            pin_o  = ser_line;
            pin_oe = 1'b1;
        end else begin
            pin_o  = pin_dat;
            pin_oe = pin_dir;
        end
    end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_txb_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int OS_RATE    = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              baud_tick,
    input  logic                              tx_en,
    input  logic                              pin_dir,
    input  logic                              pin_dat,
    input  logic                              par_en,
    input  logic                              par_odd,
    input  logic                              two_stop,
    input  logic                              wr_valid,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic                              fifo_full,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_count,
    output logic                              tx_pin_o,
    output logic                              tx_pin_oe,
    output logic                              tx_end
);
    logic              fifo_empty;
    logic [DATA_W-1:0] fifo_rd;
    logic              ser_pop;
    logic              ser_line;
    logic              ser_idle;
    frame_cfg_t        cfg;

    assign cfg    = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign tx_end = fifo_empty && ser_idle;

    txb_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!tx_en),
        .wr_en   (wr_valid && tx_en),
        .wr_data (wr_data),
        .rd_en   (ser_pop),
        .rd_data (fifo_rd),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .count   (fifo_count)
    );

    txb_shift #(.W(DATA_W), .OS(OS_RATE)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (tx_en),
        .tick      (baud_tick),
        .cfg       (cfg),
        .have_data (!fifo_empty),
        .din       (fifo_rd),
        .pop       (ser_pop),
        .line      (ser_line),
        .idle      (ser_idle)
    );

    txb_pin i_pin (
        .tx_en    (tx_en),
        .pin_dir  (pin_dir),
        .pin_dat  (pin_dat),
        .ser_line (ser_line),
        .pin_o    (tx_pin_o),
        .pin_oe   (tx_pin_oe)
    );

    // R9: one cycle after the enable falls, the transmitter reports done
    a_r9_end_after_disable : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |=> tx_end);

    // R8: a byte taken by the engine keeps tx_end low on the next cycle
    a_r8_busy_not_end : assert property (@(posedge clk) disable iff (!rst_n)
        (ser_pop && tx_en) |=> !tx_end);

endmodule

// File: tb/test_uart_tx_brk.sv
`timescale 1ns/1ps
module test_uart_tx_brk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       pin_dir = 1'b0;
    logic       pin_dat = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_full;
    logic [2:0] fifo_count;
    logic       tx_pin_o;
    logic       tx_pin_oe;
    logic       tx_end;

    int checks = 0;
    int errors = 0;
    int div = 1;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    logic [11:0] exp_bits[$];
    int          exp_len[$];

    always #2.5 clk = ~clk;

    uart_tx_brk i_uart_tx_brk (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .pin_dir(pin_dir), .pin_dat(pin_dat), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .wr_valid(wr_valid), .wr_data(wr_data),
        .fifo_full(fifo_full), .fifo_count(fifo_count), .tx_pin_o(tx_pin_o),
        .tx_pin_oe(tx_pin_oe), .tx_end(tx_end)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // tick generator: one pulse every div cycles
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (cnt >= div - 1) begin
                baud_tick = 1'b1;
                cnt = 0;
            end else begin
                baud_tick = 1'b0;
                cnt++;
            end
        end
    end

    // driver: push the expected frame for every accepted byte
    task automatic send(input logic [7:0] d, input bit track);
        logic [11:0] f;
        int          n;
        @(negedge clk);
        if (track && tx_en && !fifo_full) begin
            f = '1;
            f[0] = 1'b0;
            for (int i = 0; i < 8; i++) f[1+i] = d[i];
            n = 9;
            if (par_en) begin
                f[n] = par_odd ? ~^d : ^d;
                n++;
            end
            n += two_stop ? 2 : 1;
            exp_bits.push_back(f);
            exp_len.push_back(n);
        end
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!(tx_end && exp_bits.size() == 0));
        repeat (4) @(negedge clk);
        check(tx_end == 1'b1 && tx_pin_o == 1'b1, "R8 idle after frames", {tx_end, tx_pin_o}, 3);
    endtask

    // monitor: sample each bit in its middle and compare with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && tx_en && tx_pin_oe && tx_pin_o == 1'b0) begin
                if (exp_bits.size() == 0) begin
                    check(1'b0, "R7/R10 unexpected frame", 0, 1);
                    do @(negedge clk); while (tx_pin_o == 1'b0);
                end else begin
                    logic [11:0] e;
                    logic [11:0] a;
                    int          n;
                    bit          end_ok;
                    e = exp_bits.pop_front();
                    n = exp_len.pop_front();
                    a = '1;
                    end_ok = 1'b1;
                    repeat (8 * div) @(negedge clk);
                    a[0] = tx_pin_o;
                    if (tx_end) end_ok = 1'b0;
                    for (int i = 1; i < n; i++) begin
                        repeat (16 * div) @(negedge clk);
                        a[i] = tx_pin_o;
                        if (tx_end) end_ok = 1'b0;
                    end
                    check(a == e, "R3/R4/R5/R6 frame bits", a, e);
                    check(end_ok, "R8 tx_end low during frame", end_ok, 1);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int run;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(tx_pin_oe == 1'b0, "R1 oe in reset", tx_pin_oe, 0);
        check(tx_end == 1'b1 && fifo_count == 0, "R1 end/count in reset", {tx_end, fifo_count}, 8);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_end == 1'b1 && fifo_count == 0 && tx_pin_oe == 1'b0, "R1 after reset",
              {tx_end, fifo_count, tx_pin_oe}, 16);

        // R2 port control while disabled
        pin_dir = 1'b1; pin_dat = 1'b1; #1;
        check(tx_pin_o == 1'b1 && tx_pin_oe == 1'b1, "R2 drive high", {tx_pin_o, tx_pin_oe}, 3);
        pin_dat = 1'b0; #1;
        check(tx_pin_o == 1'b0 && tx_pin_oe == 1'b1, "R2 drive low", {tx_pin_o, tx_pin_oe}, 1);
        pin_dir = 1'b0; #1;
        check(tx_pin_oe == 1'b0, "R2 released", tx_pin_oe, 0);
        pin_dir = 1'b1; pin_dat = 1'b1;

        // R9 writes while disabled are dropped
        send(8'h5A, 1'b0);
        check(fifo_count == 0, "R9 write while disabled", fifo_count, 0);

        // R3 enable: idle high, no frame
        @(negedge clk);
        tx_en = 1'b1; mon_on = 1'b1;
        repeat (40) @(negedge clk);
        check(tx_pin_o == 1'b1 && tx_pin_oe == 1'b1 && tx_end == 1'b1, "R3 idle mark",
              {tx_pin_o, tx_pin_oe, tx_end}, 7);

        // R3 plain frames
        send(8'h00, 1'b1); send(8'hA5, 1'b1); send(8'hFF, 1'b1);
        wait_done();
        // R4 even then odd parity
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h01, 1'b1); send(8'h03, 1'b1);
        wait_done();
        par_odd = 1'b1;
        send(8'h01, 1'b1); send(8'h00, 1'b1);
        wait_done();
        // R5 two stop bits
        par_en = 1'b0; two_stop = 1'b1;
        send(8'h81, 1'b1); send(8'h7E, 1'b1);
        wait_done();
        two_stop = 1'b0;

        // R7 buffer order and full drop
        send(8'h11, 1'b1);
        repeat (3) @(negedge clk);
        send(8'h22, 1'b1); send(8'h33, 1'b1); send(8'h44, 1'b1); send(8'h55, 1'b1);
        check(fifo_full == 1'b1 && fifo_count == 4, "R7 full at depth", {fifo_full, fifo_count}, 12);
        send(8'h66, 1'b1);
        check(fifo_count == 4, "R7 write while full dropped", fifo_count, 4);
        wait_done();

        // R6 exact bit length with a slow tick
        mon_on = 1'b0; div = 3;
        send(8'h01, 1'b0);
        do @(negedge clk); while (tx_pin_o != 1'b0);
        run = 0;
        while (tx_pin_o == 1'b0) begin
            run++;
            @(negedge clk);
        end
        check(run == 48, "R6 start bit length", run, 48);
        do @(negedge clk); while (!tx_end);
        mon_on = 1'b1; par_en = 1'b1;
        send(8'hC3, 1'b1);
        wait_done();
        par_en = 1'b0; div = 1;
        repeat (4) @(negedge clk);

        // R9/R10 break during transmission
        mon_on = 1'b0;
        send(8'h12, 1'b0); send(8'h34, 1'b0); send(8'h56, 1'b0);
        repeat (40) @(negedge clk);
        check(tx_end == 1'b0, "R8 busy mid-frame", tx_end, 0);
        pin_dat = 1'b0;
        @(negedge clk);
        tx_en = 1'b0; #1;
        check(tx_pin_o == 1'b0 && tx_pin_oe == 1'b1, "R10 break driven", {tx_pin_o, tx_pin_oe}, 1);
        @(negedge clk);
        check(tx_end == 1'b1 && fifo_count == 0, "R9 reinit", {tx_end, fifo_count}, 8);
        run = 0;
        repeat (60) begin
            @(negedge clk);
            if (tx_pin_o == 1'b0 && tx_pin_oe == 1'b1) run++;
        end
        check(run == 60, "R10 break held", run, 60);
        pin_dat = 1'b1;
        @(negedge clk);
        tx_en = 1'b1; mon_on = 1'b1;
        run = 0;
        repeat (300) begin
            @(negedge clk);
            if (tx_pin_o == 1'b1) run++;
        end
        check(run == 300 && tx_end == 1'b1, "R10 no resume after break", run, 300);

        // normal frame after break
        send(8'h3C, 1'b1);
        wait_done();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule